// File: doc/BRIEF.md
# Square-Wave Tone Bank

The block makes four independent square-wave tones from one system clock. A shared divider turns the system clock into a one-cycle audio tick every `DIV_RATIO` clocks. Each channel holds a 16-bit reload word and a 16-bit down-counter, and it drives one polarity bit.

On each tick, a channel whose counter is zero reloads it from the reload word. A channel whose counter is not zero counts down by one. The polarity bit inverts only when the counter goes from 1 to 0. A reload word of N (N ≥ 1) therefore holds each output level for N+1 ticks. A reload word of zero holds the output high.

Software sets the reload words through a simple write port. Channel k sits at port address `BASE_PORT + k`, which is addresses 4 to 7 by default. A write to any other address has no effect. Volume, mixing and sample output are handled outside this block.

Top module: `tone_bank`

## Requirements
- R1: `tick_o` is high for exactly one clock in every `DIV_RATIO` (default 34) clocks. The first pulse comes in the `DIV_RATIO-1`th clock after reset is released.
- R2: After reset, every counter and every reload word is zero, every polarity is high, `tone_o` is 4'b1111 and `tick_o` is low.
- R3: A write with `wr_addr_i` equal to 4+k (k = 0..3) stores `wr_data_i` as the reload word of channel k, which drives `tone_o[k]`. A write to any other address leaves every channel unchanged.
- R4: On a tick where a channel's counter is zero, the counter takes the current reload word.
- R5: On a tick where the counter is not zero, the counter decrements. The channel's polarity inverts only on a tick where the counter steps from 1 to 0.
- R6: While a channel's reload word is zero, its output is high. The output reads high from the clock after the write that set it to zero.
- R7: A write to a reload word does not alter that channel's running counter or polarity. The new value is used at the next reload.
- R8: With a constant reload word N ≥ 1, each output level lasts N+1 ticks. For example, N=1 gives 2 ticks, N=3 gives 4 ticks and N=5 gives 6 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Port write strobe |
| wr_addr_i | input | 4 | Port address of the write |
| wr_data_i | input | 16 | Reload word to store |
| tick_o | output | 1 | Audio timer tick, one clock wide |
| tone_o | output | 4 | Polarity bit of each channel |

## Verification
An internal fault in a channel shows up as a tone edge in the wrong place at `tone_o`. A wrong counter value or a dropped reload moves the next edge by at least one tick, which is 34 clocks, and it does so within one half-period of the tone. A polarity bit that is stuck or flips by mistake is visible at the very next sampled clock, because the bench predicts every output on every clock. A divider fault changes the tick spacing and is seen within one tick interval.

// File: rtl/tone_pkg.sv
package tone_pkg;
  localparam int unsigned CNT_W   = 16;
  localparam int unsigned ADDR_W  = 4;
  typedef logic [CNT_W-1:0]  tone_word_t;
  typedef logic [ADDR_W-1:0] port_addr_t;
endpackage

// File: rtl/tone_tick_div.sv
module tone_tick_div #(
  parameter int unsigned DIV_RATIO = 34,
  localparam int unsigned DW = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam logic [DW-1:0] LAST = DW'(DIV_RATIO - 1);

  logic [DW-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else                    div_q <= div_q + 1'b1;
  end

  assign tick_o = (div_q == LAST);

  a_r1_div_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_q <= LAST);
  a_r1_tick_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (!tick_o && div_q == '0));
endmodule

// File: rtl/tone_channel.sv
module tone_channel
  import tone_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       load_i,
  input  tone_word_t reload_i,
  output logic       tone_o
);
  tone_word_t reload_q;
  tone_word_t cnt_q;
  logic       pol_q;
  logic       at_zero;
  logic       at_one;
  logic       idle;

  assign at_zero = (cnt_q == '0);
  assign at_one  = (cnt_q == tone_word_t'(1));
  assign idle    = (reload_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     reload_q <= '0;
    else if (load_i) reload_q <= reload_i;
  end

  // Counter only moves on ticks; register writes never touch it.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (tick_i) begin
      if (at_zero)    cnt_q <= reload_q;
      else            cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               pol_q <= 1'b1;
    else if (idle)             pol_q <= 1'b1;
    else if (tick_i && at_one) pol_q <= ~pol_q;
  end

  assign tone_o = pol_q | idle;

  a_r4_reload_on_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && at_zero) |=> (cnt_q == $past(reload_q)));
  a_r5_decrement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !at_zero) |=> (cnt_q == $past(cnt_q) - 1'b1));
  a_r5_flip_only_at_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle && !(tick_i && at_one)) |=> $stable(pol_q));
  a_r6_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle |=> pol_q);
  a_r7_no_tick_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/tone_bank.sv
module tone_bank
  import tone_pkg::*;
#(
  parameter int unsigned DIV_RATIO = 34,
  parameter int unsigned NUM_CH    = 4,
  parameter int unsigned BASE_PORT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic              tick_o,
  output logic [NUM_CH-1:0] tone_o
);
  logic              tick;
  logic [NUM_CH-1:0] sel;

  tone_tick_div #(.DIV_RATIO(DIV_RATIO)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    localparam port_addr_t MY_ADDR = port_addr_t'(BASE_PORT + k);
    assign sel[k] = wr_en_i && (wr_addr_i == MY_ADDR);

    tone_channel u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick),
      .load_i   (sel[k]),
      .reload_i (wr_data_i),
      .tone_o   (tone_o[k])
    );
  end

  assign tick_o = tick;

  a_r3_one_channel_per_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel));
  a_r3_no_select_without_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |-> (sel == '0));
endmodule

// File: tb/tone_bank_bench.sv
module tone_bank_bench;
  localparam int DIV = 34;
  localparam int NCH = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic        tick_o;
  logic [3:0]  tone_o;

  int checks = 0;
  int errors = 0;
  bit run = 1'b0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  tone_bank u_tone_bank (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .tick_o, .tone_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Scoreboard: reference model pushes the expected output for the next clock,
  // the monitor pops and compares it one clock later.
  logic [15:0] m_cnt [NCH];
  logic [15:0] m_rel [NCH];
  logic        m_pol [NCH];
  logic [3:0]  exp_q [$];

  always @(negedge clk_i) begin
    if (run) begin
      logic [3:0] e;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        chk(tone_o == e, "R4 R5 R6 R7 tone model", int'(tone_o), int'(e));
      end
      for (int c = 0; c < NCH; c++) begin
        logic [15:0] old_rel;
        old_rel = m_rel[c];
        if (old_rel == 0) m_pol[c] = 1'b1;
        else if (tick_o && m_cnt[c] == 16'd1) m_pol[c] = ~m_pol[c];
        if (tick_o) m_cnt[c] = (m_cnt[c] == 0) ? old_rel : m_cnt[c] - 16'd1;
        if (wr_en_i && wr_addr_i == 4'(4 + c)) m_rel[c] = wr_data_i;  // R3 decode
        e[c] = m_pol[c] | (m_rel[c] == 0);
      end
      exp_q.push_back(e);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(posedge clk_i); #1;
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0;
  endtask

  // Ticks between two consecutive edges of one channel.
  task automatic half_period(input int c, input int n);
    int ticks;
    logic last;
    @(negedge clk_i); last = tone_o[c];
    while (tone_o[c] == last) @(negedge clk_i);
    last = tone_o[c];
    ticks = 0;
    while (tone_o[c] == last) begin
      @(negedge clk_i);
      if (tick_o) ticks++;
    end
    chk(ticks == n + 1, "R8 half period", ticks, n + 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int k;
    for (int c = 0; c < NCH; c++) begin
      m_cnt[c] = '0; m_rel[c] = '0; m_pol[c] = 1'b1;
    end
    repeat (3) @(negedge clk_i);
    chk(tone_o == 4'hF, "R2 reset tone", int'(tone_o), 15);
    chk(tick_o == 1'b0, "R2 reset tick", int'(tick_o), 0);
    rst_ni = 1'b1;
    run = 1'b1;
    k = 0;
    do begin @(negedge clk_i); k++; end while (!tick_o && k < 200);
    chk(k == DIV - 1, "R1 first tick", k, DIV - 1);
    for (int p = 0; p < 3; p++) begin
      k = 0;
      do begin @(negedge clk_i); k++; end while (!tick_o && k < 200);
      chk(k == DIV, "R1 tick spacing", k, DIV);
    end
    chk(tone_o == 4'hF, "R6 idle after reset", int'(tone_o), 15);

    wr(4'd4, 16'd1);
    wr(4'd5, 16'd5);
    wr(4'd7, 16'd3);
    wr(4'd3, 16'd2);   // R3: below the channel range
    wr(4'd8, 16'd2);   // R3: above the channel range
    @(negedge clk_i);
    chk(tone_o[2] == 1'b1, "R3 R6 untouched channel high", int'(tone_o[2]), 1);
    half_period(0, 1);
    half_period(1, 5);
    half_period(3, 3);
    chk(tone_o[2] == 1'b1, "R3 R6 channel 2 still high", int'(tone_o[2]), 1);

    wr(4'd6, 16'd2);
    half_period(2, 2);
    wr(4'd5, 16'd1);   // R7: mid-run change checked by the model
    repeat (300) @(negedge clk_i);
    half_period(1, 1);

    wr(4'd4, 16'd0);
    @(negedge clk_i);
    chk(tone_o[0] == 1'b1, "R6 zero forces high", int'(tone_o[0]), 1);
    repeat (4 * DIV * 3) @(negedge clk_i);
    chk(tone_o[0] == 1'b1, "R6 stays high", int'(tone_o[0]), 1);
    wr(4'd4, 16'd4);
    repeat (20 * DIV) @(negedge clk_i);
    half_period(0, 4);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule